// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block fronts a 2K x 8 register array that behaves like a byte-writable nonvolatile memory behind an asynchronous static-RAM style strobe interface. Three active-low strobes (select, output enable, write strobe) are brought into the clock domain by a multi-stage synchronizer. The block then decodes reads, byte writes and the chip-clear gesture from the synchronized levels and their edges.

A byte write latches its address when the write window opens and its data when the window closes. It then runs for a fixed number of clock cycles while the ready line is held low. A read issued during that time returns the inverted top bit of the byte in flight. Writes are refused while the supply-good input is low and for a programmable settling delay after it returns. They are also refused while output enable is asserted and while the chip-clear qualifier is raised. Holding the write strobe low for long enough with the clear qualifier raised fills the main array with ones. When the identification qualifier is raised, the topmost 32 addresses select a separate 32-byte identification store.

Top module: `bwmem_ctrl`

## Requirements
- R1: A read is decoded when sel_n=0, outen_n=0 and wstb_n=1; rvalid_o then goes to 1 and rdata_o carries the stored byte at mem_addr. In every other strobe combination rvalid_o is 0 and rdata_o is 0.
- R2: The write address is taken when the later of sel_n and wstb_n falls (with outen_n high). The write data is taken when the earlier of them rises. Changing mem_addr after the window opens does not move the write, and changing wdata_i before the window closes does change the byte written.
- R3: From the cycle after a write is accepted, ready_o is 0 for exactly WRITE_CYC cycles. The array is updated when ready_o returns to 1.
- R4: While ready_o is 0, a read returns bit 7 of the in-flight byte inverted on rdata_o[7], and the in-flight bits 6..0 unchanged on rdata_o[6:0]. Once the write finishes, reads return the true stored byte.
- R5: A write strobe pulse taken while outen_n is 0 writes nothing and leaves ready_o at 1.
- R6: Writes are refused while pwr_good_i is 0 and for POR_CYC cycles after pwr_good_i becomes 1 or reset is released.
- R7: A write strobe pulse that arrives while ready_o is 0 is ignored. The in-flight write and the addressed byte are unaffected.
- R8: With clr_hv_i=1, holding sel_n=0 and wstb_n=0 for CLR_CYC synchronized cycles sets every main-array byte to 8'hFF. A shorter pulse changes nothing, and no byte write is made while clr_hv_i is 1. The identification store is not cleared.
- R9: With id_hv_i=1, addresses 0x7E0 to 0x7FF read and write a separate 32-byte identification store, indexed by mem_addr[4:0]. With id_hv_i=0, or at other addresses, the main array is used.
- R10: During and right after reset, ready_o is 1, rvalid_o is 0 and rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | input | 11 | Byte address |
| wdata_i | input | 8 | Write data |
| sel_n | input | 1 | Active-low device select |
| outen_n | input | 1 | Active-low output enable |
| wstb_n | input | 1 | Active-low write strobe |
| id_hv_i | input | 1 | High-voltage qualifier that maps the top 32 addresses to the identification store |
| clr_hv_i | input | 1 | High-voltage qualifier that turns a long write strobe into a chip clear |
| pwr_good_i | input | 1 | Supply above the write-sense threshold |
| rdata_o | output | 8 | Read data, zero when not reading |
| rvalid_o | output | 1 | Read data valid (low stands for high impedance) |
| ready_o | output | 1 | Ready line; 0 while a self-timed write runs |

## Verification
On every cycle, the assertions check four things. No write starts unless the power interlock is open and the clear qualifier is low. The write timer stays inside its window and the latched address and data hold still while busy. A read returns the inverted top bit during a write, and valid drops once select or output enable is released. A chip clear never fires during a write. Only the bench's scenarios can show whether the right byte lands at the right address. That covers the address-at-open and data-at-close capture, the refusal of writes under each interlock, the separation of the identification store from the main array, and a clear that fills the whole array while a short pulse leaves it alone.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
   // synchronized strobe levels, all active low
   typedef struct packed {
      logic sel_n;
      logic outen_n;
      logic wstb_n;
   } strb_t;

   localparam int STRB_W = $bits(strb_t);
endpackage

// File: rtl/bwm_sync.sv
module bwm_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bwm_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bwm_sync: W must be positive");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/bwm_store.sv
module bwm_store #(
   parameter int AW    = 11,
   parameter int DW    = 8,
   parameter int ID_AW = 5
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_id,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          clr_all,
   input  logic          rd_id,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH    = 1 << AW;
   localparam int ID_DEPTH = 1 << ID_AW;

   logic [DW-1:0] main_q [DEPTH];
   logic [DW-1:0] id_q   [ID_DEPTH];

   always_ff @(posedge clk) begin
      if (clr_all) begin
         for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
      end else if (wr_en && !wr_id) begin
         main_q[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_id) id_q[wr_addr[ID_AW-1:0]] <= wr_data;
   end

   assign rd_data = rd_id ? id_q[rd_addr[ID_AW-1:0]] : main_q[rd_addr];
endmodule

// File: rtl/bwm_write_seq.sv
module bwm_write_seq
   import bwm_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 8,
   parameter int ID_AW     = 5,
   parameter int WRITE_CYC = 50000,
   parameter int POR_CYC   = 250000,
   parameter int CLR_CYC   = 500000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  strb_t         syn,
   input  logic          clr_hv,
   input  logic          pwr_good,
   input  logic          id_hv,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] din,
   output logic          busy,
   output logic [AW-1:0] lat_addr,
   output logic          lat_id,
   output logic [DW-1:0] lat_data,
   output logic          wr_pulse,
   output logic          clr_pulse
);
   localparam int TW = $clog2(WRITE_CYC);
   localparam int PW = $clog2(POR_CYC + 1);
   localparam int CW = $clog2(CLR_CYC + 1);
   localparam logic [TW-1:0] T_LAST  = TW'(WRITE_CYC - 1);
   localparam logic [PW-1:0] P_DONE  = PW'(POR_CYC);
   localparam logic [CW-1:0] C_FULL  = CW'(CLR_CYC);
   localparam logic [CW-1:0] C_LAST  = CW'(CLR_CYC - 1);
   localparam logic [AW-1:0] ID_BASE = AW'((1 << AW) - (1 << ID_AW));

   logic          act, act_q, armed, wr_ok, start, stop, commit, clr_arm;
   logic [TW-1:0] tmr;
   logic [PW-1:0] por_cnt;
   logic [CW-1:0] clr_cnt;

   // power-on interlock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         por_cnt <= '0;
      else if (!pwr_good) por_cnt <= '0;
      else if (por_cnt != P_DONE) por_cnt <= por_cnt + 1'b1;
   end
   assign wr_ok = pwr_good && (por_cnt == P_DONE);

   // write window: select and strobe low, output enable high, no clear qualifier
   assign act    = !syn.sel_n && !syn.wstb_n && syn.outen_n && !clr_hv;
   assign start  = act && !act_q && !busy;
   assign stop   = !act && act_q;
   assign commit = stop && armed && syn.outen_n && !clr_hv && !busy && wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         armed    <= 1'b0;
         lat_addr <= '0;
         lat_id   <= 1'b0;
         lat_data <= '0;
      end else begin
         act_q <= act;
         if (start) begin
            armed    <= 1'b1;
            lat_addr <= mem_addr;
            lat_id   <= id_hv && (mem_addr >= ID_BASE);
         end else if (stop) begin
            armed <= 1'b0;
         end
         if (commit) lat_data <= din;
      end
   end

   // self-timed write cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (commit) begin
         busy <= 1'b1;
         tmr  <= '0;
      end else if (busy) begin
         tmr <= tmr + 1'b1;
         if (tmr == T_LAST) busy <= 1'b0;
      end
   end
   assign wr_pulse = busy && (tmr == T_LAST);

   // chip clear: long strobe under the clear qualifier
   assign clr_arm = !syn.sel_n && !syn.wstb_n && clr_hv && wr_ok && !busy;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         clr_cnt <= '0;
      else if (!clr_arm)  clr_cnt <= '0;
      else if (clr_cnt != C_FULL) clr_cnt <= clr_cnt + 1'b1;
   end
   assign clr_pulse = clr_arm && (clr_cnt == C_LAST);

   AST_START_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wr_ok) && !$past(clr_hv) && $past(syn.outen_n))); // R6
   AST_TIMER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tmr <= T_LAST)); // R3
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data) && $stable(lat_id))); // R7
   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |-> (!busy && wr_ok)); // R8
endmodule

// File: rtl/bwmem_ctrl.sv
module bwmem_ctrl
   import bwm_pkg::*;
#(
   parameter int AW          = 11,
   parameter int DW          = 8,
   parameter int ID_AW       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int WRITE_CYC   = 50000,
   parameter int POR_CYC     = 250000,
   parameter int CLR_CYC     = 500000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] wdata_i,
   input  logic          sel_n,
   input  logic          outen_n,
   input  logic          wstb_n,
   input  logic          id_hv_i,
   input  logic          clr_hv_i,
   input  logic          pwr_good_i,
   output logic [DW-1:0] rdata_o,
   output logic          rvalid_o,
   output logic          ready_o
);
   localparam logic [AW-1:0] ID_BASE = AW'((1 << AW) - (1 << ID_AW));

   if (DW < 2) begin : g_bad_dw
      $error("bwmem_ctrl: DW must be at least 2");
   end
   if (ID_AW >= AW) begin : g_bad_id
      $error("bwmem_ctrl: identification area must be smaller than the array");
   end
   if (WRITE_CYC < 2 || POR_CYC < 1 || CLR_CYC < 2) begin : g_bad_time
      $error("bwmem_ctrl: timing parameters out of range");
   end

   strb_t               syn;
   logic [STRB_W-1:0]   syn_v;
   logic                busy, lat_id, wr_pulse, clr_pulse, rd_req, rd_id;
   logic [AW-1:0]       lat_addr;
   logic [DW-1:0]       lat_data, arr_data;

   bwm_sync #(.W(STRB_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({sel_n, outen_n, wstb_n}),
      .q   (syn_v)
   );
   assign syn = strb_t'(syn_v);

   bwm_write_seq #(
      .AW(AW), .DW(DW), .ID_AW(ID_AW),
      .WRITE_CYC(WRITE_CYC), .POR_CYC(POR_CYC), .CLR_CYC(CLR_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .syn       (syn),
      .clr_hv    (clr_hv_i),
      .pwr_good  (pwr_good_i),
      .id_hv     (id_hv_i),
      .mem_addr  (mem_addr),
      .din       (wdata_i),
      .busy      (busy),
      .lat_addr  (lat_addr),
      .lat_id    (lat_id),
      .lat_data  (lat_data),
      .wr_pulse  (wr_pulse),
      .clr_pulse (clr_pulse)
   );

   assign rd_id = id_hv_i && (mem_addr >= ID_BASE);

   bwm_store #(.AW(AW), .DW(DW), .ID_AW(ID_AW)) u_store (
      .clk     (clk),
      .wr_en   (wr_pulse),
      .wr_id   (lat_id),
      .wr_addr (lat_addr),
      .wr_data (lat_data),
      .clr_all (clr_pulse),
      .rd_id   (rd_id),
      .rd_addr (mem_addr),
      .rd_data (arr_data)
   );

   assign rd_req  = !syn.sel_n && !syn.outen_n && syn.wstb_n;
   assign ready_o = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= rd_req;
         if (!rd_req)   rdata_o <= '0;
         else if (busy) rdata_o <= {~lat_data[DW-1], lat_data[DW-2:0]};
         else           rdata_o <= arr_data;
      end
   end

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (syn.sel_n || syn.outen_n) |=> (!rvalid_o && rdata_o == '0)); // R1
   AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_req) |=> (rdata_o[DW-1] == ~$past(lat_data[DW-1]))); // R4
endmodule

// File: tb/tb_bwmem_ctrl.sv
module tb_bwmem_ctrl;
   localparam int WCYC = 40;
   localparam int PCYC = 30;
   localparam int CCYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] mem_addr = '0;
   logic [7:0]  wdata_i = '0;
   logic        sel_n = 1'b1, outen_n = 1'b1, wstb_n = 1'b1;
   logic        id_hv_i = 1'b0, clr_hv_i = 1'b0, pwr_good_i = 1'b1;
   logic [7:0]  rdata_o;
   logic        rvalid_o, ready_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bwmem_ctrl #(.WRITE_CYC(WCYC), .POR_CYC(PCYC), .CLR_CYC(CCYC)) dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .wdata_i(wdata_i),
      .sel_n(sel_n), .outen_n(outen_n), .wstb_n(wstb_n),
      .id_hv_i(id_hv_i), .clr_hv_i(clr_hv_i), .pwr_good_i(pwr_good_i),
      .rdata_o(rdata_o), .rvalid_o(rvalid_o), .ready_o(ready_o)
   );

   // {addr, data}
   localparam logic [18:0] VEC [6] = '{
      {11'h000, 8'h5A}, {11'h001, 8'hA5}, {11'h3FF, 8'h80},
      {11'h400, 8'h01}, {11'h7FF, 8'hFF}, {11'h7E5, 8'h12}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      mem_addr = a; wdata_i = d; sel_n = 1'b0; outen_n = 1'b1;
      cyc(4); wstb_n = 1'b0;
      cyc(6); wstb_n = 1'b1;
      cyc(4); sel_n = 1'b1;
      cyc(2);
   endtask

   task automatic do_read(input logic [10:0] a, output logic [7:0] d, output logic v);
      @(negedge clk);
      mem_addr = a; sel_n = 1'b0; outen_n = 1'b0; wstb_n = 1'b1;
      cyc(5);
      d = rdata_o; v = rvalid_o;
      sel_n = 1'b1; outen_n = 1'b1;
      cyc(3);
   endtask

   task automatic expect_byte(input logic [10:0] a, input logic [7:0] e, input string req);
      logic [7:0] d; logic v;
      do_read(a, d, v);
      check(v === 1'b1 && d === e, req, {v, d}, {1'b1, e});
   endtask

   task automatic clear_pulse(input int hold);
      @(negedge clk);
      clr_hv_i = 1'b1; outen_n = 1'b1; sel_n = 1'b0;
      cyc(2); wstb_n = 1'b0;
      cyc(hold); wstb_n = 1'b1;
      cyc(3); sel_n = 1'b1;
      cyc(2); clr_hv_i = 1'b0;
      cyc(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d; logic v;
      cyc(3);
      check(ready_o === 1'b1 && rvalid_o === 1'b0 && rdata_o === 8'h00,
            "R10 reset state", {ready_o, rvalid_o, rdata_o}, {1'b1, 1'b0, 8'h00});
      rst_n = 1'b1;
      cyc(2);
      check(ready_o === 1'b1 && rvalid_o === 1'b0, "R10 after reset",
            {ready_o, rvalid_o}, 2'b10);
      cyc(PCYC + 10);

      // table walk: write each vector, then read all back
      foreach (VEC[i]) begin
         do_write(VEC[i][18:8], VEC[i][7:0]);
         check(ready_o === 1'b0, "R3 busy after write", ready_o, 0);
         cyc(WCYC + 5);
         check(ready_o === 1'b1, "R3 ready after write", ready_o, 1);
      end
      foreach (VEC[i]) expect_byte(VEC[i][18:8], VEC[i][7:0], "R1 read back");

      // no read decoded when output enable is high
      @(negedge clk); sel_n = 1'b0; outen_n = 1'b1; mem_addr = 11'h000;
      cyc(5);
      check(rvalid_o === 1'b0 && rdata_o === 8'h00, "R1 no read w/o outen",
            {rvalid_o, rdata_o}, 0);
      sel_n = 1'b1; cyc(3);

      // busy length exactly around WCYC
      do_write(11'h000, 8'h3C);
      cyc(WCYC - 15);
      check(ready_o === 1'b0, "R3 still busy near end", ready_o, 0);
      cyc(14);
      check(ready_o === 1'b1, "R3 released", ready_o, 1);
      expect_byte(11'h000, 8'h3C, "R3 array updated");

      // data polling, bit7 clear and set
      do_write(11'h001, 8'h3C);
      do_read(11'h001, d, v);
      check(v === 1'b1 && d === 8'hBC && ready_o === 1'b0, "R4 poll of 3C", d, 8'hBC);
      cyc(WCYC);
      expect_byte(11'h001, 8'h3C, "R4 true data after");
      do_write(11'h001, 8'hC3);
      do_read(11'h001, d, v);
      check(v === 1'b1 && d === 8'h43, "R4 poll of C3", d, 8'h43);
      cyc(WCYC);
      expect_byte(11'h001, 8'hC3, "R4 true data after C3");

      // second write during busy is ignored
      do_write(11'h3FF, 8'h11);
      do_write(11'h400, 8'h22);
      cyc(WCYC);
      expect_byte(11'h400, 8'h01, "R7 ignored while busy");
      expect_byte(11'h3FF, 8'h11, "R7 first write kept");

      // address at window open, data at window close
      @(negedge clk);
      mem_addr = 11'h010; wdata_i = 8'h00; sel_n = 1'b0; outen_n = 1'b1;
      cyc(4); wstb_n = 1'b0;
      cyc(6); mem_addr = 11'h000; wdata_i = 8'h77;
      cyc(4); wstb_n = 1'b1;
      cyc(4); sel_n = 1'b1;
      cyc(WCYC + 5);
      expect_byte(11'h010, 8'h77, "R2 addr at open data at close");
      expect_byte(11'h000, 8'h3C, "R2 later addr untouched");

      // output enable low blocks write
      @(negedge clk);
      mem_addr = 11'h010; wdata_i = 8'h99; sel_n = 1'b0; outen_n = 1'b0;
      cyc(4); wstb_n = 1'b0;
      cyc(6); wstb_n = 1'b1;
      cyc(4); sel_n = 1'b1; outen_n = 1'b1;
      check(ready_o === 1'b1, "R5 no busy with outen low", ready_o, 1);
      cyc(3);
      expect_byte(11'h010, 8'h77, "R5 byte unchanged");

      // supply interlock and power-on delay
      pwr_good_i = 1'b0;
      do_write(11'h010, 8'h66);
      check(ready_o === 1'b1, "R6 blocked supply low", ready_o, 1);
      pwr_good_i = 1'b1;
      do_write(11'h010, 8'h55);
      check(ready_o === 1'b1, "R6 blocked in delay", ready_o, 1);
      cyc(PCYC + 5);
      expect_byte(11'h010, 8'h77, "R6 byte unchanged");
      do_write(11'h010, 8'h44);
      check(ready_o === 1'b0, "R6 allowed after delay", ready_o, 0);
      cyc(WCYC + 5);
      expect_byte(11'h010, 8'h44, "R6 written after delay");

      // delay also after reset
      @(negedge clk); rst_n = 1'b0; cyc(2); rst_n = 1'b1;
      do_write(11'h010, 8'h33);
      check(ready_o === 1'b1, "R6 blocked after reset", ready_o, 1);
      cyc(PCYC + 5);
      expect_byte(11'h010, 8'h44, "R6 unchanged after reset");

      // identification area
      id_hv_i = 1'b1;
      do_write(11'h7E5, 8'hA5);
      cyc(WCYC + 5);
      expect_byte(11'h7E5, 8'hA5, "R9 id area read");
      expect_byte(11'h010, 8'h44, "R9 outside window uses main");
      id_hv_i = 1'b0;
      expect_byte(11'h7E5, 8'h12, "R9 main unaffected");

      // chip clear: short pulse ignored, long pulse fills ones
      clear_pulse(CCYC / 2);
      check(ready_o === 1'b1, "R8 no byte write under clear", ready_o, 1);
      expect_byte(11'h010, 8'h44, "R8 short pulse no clear");
      clear_pulse(CCYC + 20);
      expect_byte(11'h010, 8'hFF, "R8 cleared 010");
      expect_byte(11'h000, 8'hFF, "R8 cleared 000");
      expect_byte(11'h7E5, 8'hFF, "R8 cleared 7E5");
      id_hv_i = 1'b1;
      expect_byte(11'h7E5, 8'hA5, "R8 id area kept");
      id_hv_i = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule